// File: doc/BRIEF.md
# Current-Mode PWM Switch Sequencer

This block is the digital gate-control core of a synchronous step-down converter. It counts out a fixed switching period in system clocks. At the start of each period it turns on the high-side switch, and it turns that switch off on the first of three events: the current ramp crossing the error-amplifier level, the high-side over-current flag, or the maximum on-time. For the rest of the period the low-side switch conducts. A gap of a programmable number of clocks with both gates low separates every hand-over between the two switches.

The analog parts (comparators, ramp, error amplifier, soft-start capacitor) stay outside the block, and each reaches it as a single-bit flag. After enable the block holds both gates low, so a pre-charged output is not pulled down. It starts switching in one of two ways:

- When the soft-start voltage passes the feedback voltage, it starts in normal operation.
- When the soft-start voltage reaches a fixed forced-start level, it starts in prebiased operation.

In prebiased operation a reverse-current (sink) limit on the low-side switch cuts that switch early. The high-side switch then runs again until its current limit or the period end. Prebiased operation hands over to normal operation at a period boundary once soft-start is above feedback.

Top module: `pwm_switch_seq`

## Requirements
- R1: While reset is active, and on the clock after `enable` is sampled low, `hsGate`, `lsGate` and `prebiasMode` are all low, and the block goes back to waiting for a start flag.
- R2: While waiting, both gates stay low. `ssAboveFb` high starts normal operation. `forcedStart` high with `ssAboveFb` low starts prebiased operation (`prebiasMode` high). When both flags are high, normal operation wins.
- R3: A period is `PERIOD_CLKS` clocks long. Its first max(`deadClks`,1) cycles have both gates low, and `hsGate` rises in the cycle after that gap.
- R4: If `rampTrip` or `hsLimit` is sampled high at a clock edge while the first high-side pulse of a period is on, `hsGate` is low in the next cycle.
- R5: The first high-side pulse of a period lasts at most MAX_ON = floor(`PERIOD_CLKS`*`DUTY_PCT`/100) cycles. With the defaults this is 95.
- R6: After the first high-side pulse ends, both gates stay low for max(`deadClks`,1) cycles. Then `lsGate` stays high until the period ends. In normal operation `lsSinkLimit` has no effect on `lsGate`.
- R7: In prebiased operation, `lsSinkLimit` sampled high while `lsGate` is high drops `lsGate` in the next cycle. After a gap of max(`deadClks`,1) cycles, `hsGate` is on again until `hsLimit` is sampled high or the period ends. After that, both gates stay low for the rest of the period.
- R8: Prebiased operation changes to normal operation (`prebiasMode` falls) only at the last edge of a period, and only if `ssAboveFb` is sampled high at that edge.
- R9: `hsGate` and `lsGate` are never high in the same cycle. Neither gate rises in the cycle right after the other was high, and a `deadClks` value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low forces both gates off |
| deadClks | input | DEAD_W | Break-before-make gap in clocks (0 acts as 1) |
| rampTrip | input | 1 | Current ramp has crossed the error-amplifier level |
| hsLimit | input | 1 | High-side over-current flag |
| lsSinkLimit | input | 1 | Low-side reverse-current limit flag |
| ssAboveFb | input | 1 | Soft-start voltage is above feedback |
| forcedStart | input | 1 | Soft-start has reached the forced-start level |
| hsGate | output | 1 | High-side switch drive |
| lsGate | output | 1 | Low-side switch drive |
| prebiasMode | output | 1 | Running in prebiased operation |

## Verification
A wrong phase or counter value inside the block shows at the gate pins within one period. Typical symptoms are a high-side pulse that starts a cycle early, a gap that is one cycle short, or a low-side pulse that is missing or cut. A wrong mode shows on `prebiasMode` at once. It also shows as a low-side pulse that ignores or wrongly obeys the sink limit the next time that limit is raised. The bench drives pseudo-random trip, limit and sink flags through every start path and gap setting. It compares both gates and the mode pin against an independent model on every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [1:0] {
    MODE_WAIT,
    MODE_NORM,
    MODE_PRE
  } mode_e;

  typedef enum logic [2:0] {
    PH_GAP_LEAD,
    PH_HS,
    PH_GAP_MID,
    PH_LS,
    PH_GAP_HS2,
    PH_HS2,
    PH_IDLE
  } phase_e;

  // strobes from the control FSM to the timing datapath
  typedef struct packed {
    logic runPeriod;
    logic clrPeriod;
    logic clrDead;
    logic clrOn;
  } strobes_t;

endpackage

// File: rtl/pss_timer.sv
module pss_timer
  import pss_pkg::*;
#(
  parameter int PERIOD_CLKS = 100,
  parameter int DUTY_PCT    = 95,
  parameter int DEAD_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DEAD_W-1:0] deadClks,
  output logic              periodEnd,
  output logic              deadDone,
  output logic              onMax
);

  localparam int PW     = $clog2(PERIOD_CLKS);
  localparam int MAX_ON = PERIOD_CLKS * DUTY_PCT / 100;
  localparam int OW     = $clog2(MAX_ON + 1);
  localparam logic [PW-1:0] LAST = PW'(PERIOD_CLKS - 1);

  logic [PW-1:0]     pCnt;
  logic [DEAD_W-1:0] dCnt;
  logic [OW-1:0]     onCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pCnt <= '0;
    end else if (stb.clrPeriod) begin
      pCnt <= '0;
    end else if (stb.runPeriod) begin
      pCnt <= (pCnt == LAST) ? '0 : pCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dCnt <= '0;
    end else if (stb.clrDead) begin
      dCnt <= '0;
    end else if (dCnt != '1) begin
      dCnt <= dCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onCnt <= '0;
    end else if (stb.clrOn) begin
      onCnt <= '0;
    end else if (onCnt != OW'(MAX_ON)) begin
      onCnt <= onCnt + 1'b1;
    end
  end

  assign periodEnd = (pCnt == LAST);
  assign deadDone  = ((DEAD_W+1)'(dCnt) + (DEAD_W+1)'(1)) >= (DEAD_W+1)'(deadClks);
  assign onMax     = ((OW+1)'(onCnt) + (OW+1)'(1)) >= (OW+1)'(MAX_ON);

  // R3: a running period wraps back to its first cycle
  a_r3_period_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (stb.runPeriod && !stb.clrPeriod && pCnt == LAST) |=> (pCnt == '0));

  // R3: counter never leaves the period range
  a_r3_period_range: assert property (@(posedge clk) disable iff (!rstN)
    pCnt <= LAST);

endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     rampTrip,
  input  logic     hsLimit,
  input  logic     lsSinkLimit,
  input  logic     ssAboveFb,
  input  logic     forcedStart,
  input  logic     periodEnd,
  input  logic     deadDone,
  input  logic     onMax,
  output strobes_t stb,
  output logic     hsGate,
  output logic     lsGate,
  output logic     prebiasMode
);

  mode_e  mode, modeN;
  phase_e ph, phN;

  always_comb begin
    modeN         = mode;
    phN           = ph;
    stb           = '0;
    stb.runPeriod = (mode != MODE_WAIT);
    if (!enable) begin
      modeN         = MODE_WAIT;
      phN           = PH_IDLE;
      stb.clrPeriod = 1'b1;
      stb.runPeriod = 1'b0;
    end else if (mode == MODE_WAIT) begin
      stb.clrPeriod = 1'b1;
      if (ssAboveFb || forcedStart) begin
        modeN       = ssAboveFb ? MODE_NORM : MODE_PRE;
        phN         = PH_GAP_LEAD;
        stb.clrDead = 1'b1;
      end
    end else if (periodEnd) begin
      phN         = PH_GAP_LEAD;
      stb.clrDead = 1'b1;
      if (mode == MODE_PRE && ssAboveFb) modeN = MODE_NORM;
    end else begin
      unique case (ph)
        PH_GAP_LEAD: if (deadDone) begin
          phN       = PH_HS;
          stb.clrOn = 1'b1;
        end
        PH_HS: if (rampTrip || hsLimit || onMax) begin
          phN         = PH_GAP_MID;
          stb.clrDead = 1'b1;
        end
        PH_GAP_MID: if (deadDone) phN = PH_LS;
        PH_LS: if (mode == MODE_PRE && lsSinkLimit) begin
          phN         = PH_GAP_HS2;
          stb.clrDead = 1'b1;
        end
        PH_GAP_HS2: if (deadDone) phN = PH_HS2;
        PH_HS2: if (hsLimit) phN = PH_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode <= MODE_WAIT;
      ph   <= PH_IDLE;
    end else begin
      mode <= modeN;
      ph   <= phN;
    end
  end

  assign hsGate      = (mode != MODE_WAIT) && (ph == PH_HS || ph == PH_HS2);
  assign lsGate      = (mode != MODE_WAIT) && (ph == PH_LS);
  assign prebiasMode = (mode == MODE_PRE);

  // R1: enable low forces everything off on the next cycle
  a_r1_enable_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!hsGate && !lsGate && !prebiasMode));

  // R9: break-before-make in both directions
  a_r9_ls_after_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lsGate) |-> !$past(hsGate));
  a_r9_hs_after_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsGate) |-> !$past(lsGate));

  // R4: an over-current flag ends a high-side pulse at once
  a_r4_limit_cuts: assert property (@(posedge clk) disable iff (!rstN)
    (hsGate && hsLimit) |=> !hsGate);

  // R5: the on-time ceiling from the timer ends the first pulse
  a_r5_max_on: assert property (@(posedge clk) disable iff (!rstN)
    (ph == PH_HS && onMax) |=> !hsGate);

  // R6: in normal operation the low side holds to the period end
  a_r6_sink_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_NORM && lsGate && enable && !periodEnd) |=> lsGate);

endmodule

// File: rtl/pwm_switch_seq.sv
module pwm_switch_seq
  import pss_pkg::*;
#(
  parameter int PERIOD_CLKS = 100,
  parameter int DUTY_PCT    = 95,
  parameter int DEAD_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DEAD_W-1:0] deadClks,
  input  logic              rampTrip,
  input  logic              hsLimit,
  input  logic              lsSinkLimit,
  input  logic              ssAboveFb,
  input  logic              forcedStart,
  output logic              hsGate,
  output logic              lsGate,
  output logic              prebiasMode
);

  strobes_t stb;
  logic     periodEnd;
  logic     deadDone;
  logic     onMax;

  pss_timer #(
    .PERIOD_CLKS(PERIOD_CLKS),
    .DUTY_PCT   (DUTY_PCT),
    .DEAD_W     (DEAD_W)
  ) timer_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .deadClks (deadClks),
    .periodEnd(periodEnd),
    .deadDone (deadDone),
    .onMax    (onMax)
  );

  pss_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .rampTrip   (rampTrip),
    .hsLimit    (hsLimit),
    .lsSinkLimit(lsSinkLimit),
    .ssAboveFb  (ssAboveFb),
    .forcedStart(forcedStart),
    .periodEnd  (periodEnd),
    .deadDone   (deadDone),
    .onMax      (onMax),
    .stb        (stb),
    .hsGate     (hsGate),
    .lsGate     (lsGate),
    .prebiasMode(prebiasMode)
  );

endmodule

// File: tb/pwm_switch_seq_tb_top.sv
module pwm_switch_seq_tb_top;

  localparam int PERIOD = 100;
  localparam int MAXON  = 95;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] deadClks = 4'd3;
  logic       rampTrip = 1'b0, hsLimit = 1'b0, lsSinkLimit = 1'b0;
  logic       ssAboveFb = 1'b0, forcedStart = 1'b0;
  logic       hsGate, lsGate, prebiasMode;

  int compared = 0, mismatched = 0, cyc = 0, pattern = 0;
  logic [31:0] lcg = 32'h1234_5678;

  // reference model state
  int mMode = 0, mSeg = 6, mPos = 0, mAge = 0;
  // directed measurements
  int hsRun = 0, hsRunMax = 0, riseCyc = -1, riseGap = 0;

  always #2.5 clk = ~clk;

  pwm_switch_seq dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .deadClks(deadClks),
    .rampTrip(rampTrip), .hsLimit(hsLimit), .lsSinkLimit(lsSinkLimit),
    .ssAboveFb(ssAboveFb), .forcedStart(forcedStart),
    .hsGate(hsGate), .lsGate(lsGate), .prebiasMode(prebiasMode)
  );

  // behavioural reference: mode 0 wait, 1 normal, 2 prebiased
  // segment 0 lead gap, 1 first hs, 2 mid gap, 3 ls, 4 gap, 5 second hs, 6 idle
  always @(posedge clk) begin
    int dl;
    dl = (deadClks == 0) ? 1 : int'(deadClks);
    cyc++;
    if (!rstN || !enable) begin
      mMode = 0; mSeg = 6; mPos = 0; mAge = 0;
    end else if (mMode == 0) begin
      if (ssAboveFb) mMode = 1;
      else if (forcedStart) mMode = 2;
      if (mMode != 0) begin mSeg = 0; mAge = 0; mPos = 0; end
    end else if (mPos == PERIOD - 1) begin
      mPos = 0; mSeg = 0; mAge = 0;
      if (mMode == 2 && ssAboveFb) mMode = 1;
    end else begin
      mPos++;
      if (mSeg == 0 || mSeg == 2 || mSeg == 4) begin
        if (mAge + 1 >= dl) begin mSeg++; mAge = 0; end else mAge++;
      end else if (mSeg == 1) begin
        if (rampTrip || hsLimit || mAge + 1 >= MAXON) begin mSeg = 2; mAge = 0; end
        else mAge++;
      end else if (mSeg == 3) begin
        if (mMode == 2 && lsSinkLimit) begin mSeg = 4; mAge = 0; end
      end else if (mSeg == 5) begin
        if (hsLimit) mSeg = 6;
      end
    end
  end

  task automatic check(input logic act, input logic exp, input string req, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, what, cyc, act, exp);
    end
  endtask

  task automatic compareAll();
    logic eHs, eLs, ePre;
    string tHs, tLs;
    eHs  = (mMode != 0) && (mSeg == 1 || mSeg == 5);
    eLs  = (mMode != 0) && (mSeg == 3);
    ePre = (mMode == 2);
    if (mMode == 0) begin
      tHs = (!rstN || !enable) ? "R1" : "R2"; tLs = tHs;
    end else begin
      tHs = (mSeg == 0) ? "R3" : (mSeg == 1) ? "R4" : (mSeg >= 4) ? "R7" : "R6";
      tLs = (mMode == 2) ? "R7" : "R6";
    end
    check(hsGate, eHs, tHs, "hsGate");
    check(lsGate, eLs, tLs, "lsGate");
    check(prebiasMode, ePre, "R8", "prebiasMode");
    check(hsGate && lsGate, 1'b0, "R9", "overlap");
    // on-run and period-spacing measurements
    if (hsGate) hsRun++;
    else hsRun = 0;
    if (hsRun > hsRunMax) hsRunMax = hsRun;
    if (hsRun == 1 && mSeg == 1) begin
      if (riseCyc >= 0) riseGap = cyc - riseCyc;
      riseCyc = cyc;
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      compareAll();
      lcg = lcg * 32'd1103515245 + 32'd12345;
      rampTrip    = (pattern == 1 || pattern == 3) && (lcg[30:24] < 7'd6);
      hsLimit     = (pattern != 0) && (lcg[22:16] < 7'd2);
      lsSinkLimit = (pattern != 0) && (lcg[14:8] < 7'd14);
    end
  endtask

  initial begin
    step(4);
    rstN = 1'b1; enable = 1'b1;
    step(200);                       // R2: no start flag, gates stay low
    forcedStart = 1'b1;              // R2, R7: prebiased start
    pattern = 3;
    step(800);
    ssAboveFb = 1'b1;                // R8: handover at a period end
    pattern = 1;
    step(800);                       // R6: sink flag ignored in normal
    pattern = 0; deadClks = 4'd2;
    step(300);
    hsRunMax = 0; riseCyc = -1;
    step(400);
    check(hsRunMax == MAXON, 1'b1, "R5", "max on-time run reached 95");
    check(riseGap == PERIOD, 1'b1, "R3", "hs rise spacing equals period");
    deadClks = 4'd0; pattern = 1;    // R9: zero gap behaves as one
    step(400);
    enable = 1'b0;                   // R1
    step(20);
    ssAboveFb = 1'b0; forcedStart = 1'b0; enable = 1'b1;
    step(100);                       // R2
    ssAboveFb = 1'b1; forcedStart = 1'b1; deadClks = 4'd15;  // R2 priority
    step(500);
    enable = 1'b0; ssAboveFb = 1'b0; deadClks = 4'd1;
    step(5);
    enable = 1'b1; pattern = 3;      // R7: second high-side pulses
    step(900);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule